// File: doc/BRIEF.md
# Branch Landing Guard

This block observes the stream of retired instructions and checks that every tracked indirect call or indirect jump is followed by a landing marker instruction. Each retired descriptor carries an instruction class, a prefix flag that exempts a branch from tracking, the execution mode, the privilege domain, the instruction address and a flag saying the instruction sits in a page of untracked legacy code.

Each privilege domain, user and supervisor, has its own two-state tracker. A tracked indirect transfer moves that domain into a waiting state. The next instruction retired in that domain must then be the landing marker that matches the current mode, and otherwise the block raises a coded protection fault. A master enable and one enable for each domain control whether tracking is active.

The fault output is a single-cycle pulse. The fault code and the address of the offending instruction stay in registers until the next fault. The per-domain waiting states are brought out so that the surrounding logic can see them.

Top module: `branch_land_guard`

## Requirements
- R1: After reset, trackUser and trackSup are 0, faultPulse is 0, and faultCode and faultAddr are 0.
- R2: A valid descriptor with class 1 (indirect call) or class 2 (indirect jump) and retNoTrack=0, in an idle enabled domain (retPriv=1 user, retPriv=0 supervisor), sets that domain's tracking output one cycle later.
- R3: While a domain is waiting, a mode-correct marker as its next valid descriptor clears the wait one cycle later and raises no fault.
- R4: While a domain is waiting, any other next descriptor in that domain (one not covered by R3 or R7) gives faultPulse=1 for exactly one cycle, one cycle later, with faultCode=3 and faultAddr equal to that descriptor's address. The domain returns to idle and is not re-armed by that descriptor.
- R5: An indirect call or jump with retNoTrack=1 does not arm the tracker.
- R6: Class 3 (32-bit marker) is accepted only when retMode is 0 (protected 32-bit) or 1 (compatibility). Class 4 (64-bit marker) is accepted only when retMode is 2 (64-bit). A marker in the wrong mode counts as a violation under R4.
- R7: While a domain is waiting, a next descriptor with retLegacy=1 returns the domain to idle without a fault.
- R8: With masterEn=0, neither domain arms and any waiting domain is cleared. With userEn=0 or supEn=0, only that domain is held idle and the other domain keeps working.
- R9: A marker (class 3 or 4) retired while its domain is idle changes no state and raises no fault.
- R10: Descriptors of one domain never change the tracking state of the other domain.
- R11: faultCode and faultAddr hold their values in every cycle in which faultPulse is 0.
- R12: A cycle with retValid=0 changes no tracking state while the enables stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Global tracking enable |
| userEn | input | 1 | Tracking enable for the user domain |
| supEn | input | 1 | Tracking enable for the supervisor domain |
| retValid | input | 1 | A descriptor is retired this cycle |
| retClass | input | 3 | 0 other, 1 indirect call, 2 indirect jump, 3 32-bit marker, 4 64-bit marker |
| retNoTrack | input | 1 | Branch carries the tracking-exempt prefix |
| retMode | input | 2 | 0 protected 32-bit, 1 compatibility, 2 64-bit, 3 reserved |
| retPriv | input | 1 | 1 user domain, 0 supervisor domain |
| retAddr | input | ADDR_W | Address of the retired instruction |
| retLegacy | input | 1 | Instruction lies in a legacy page |
| trackUser | output | 1 | User domain is waiting for a marker |
| trackSup | output | 1 | Supervisor domain is waiting for a marker |
| faultPulse | output | 1 | One-cycle protection fault strobe |
| faultCode | output | 8 | Held fault code (3 for a missing marker) |
| faultAddr | output | ADDR_W | Held address of the offending instruction |

## Verification
The properties assume that retPriv, retNoTrack and the enables are meaningful only on cycles that they qualify. They also assume that the domain enables are settled for the cycle in which a hold-state property is judged. The bench therefore changes an enable only in a cycle with no retired descriptor, and it drives retired descriptors one per cycle, interleaving the two domains only in the separation scenario. Reserved mode 3 and unused class codes are never driven, so every expected outcome follows directly from R2 to R10.

// File: rtl/blg_pkg.sv
package blg_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN  = 3'd0,
    CLS_ICALL  = 3'd1,
    CLS_IJMP   = 3'd2,
    CLS_MARK32 = 3'd3,
    CLS_MARK64 = 3'd4
  } instClass_t;

  typedef enum logic [1:0] {
    MODE_PROT32 = 2'd0,
    MODE_COMPAT = 2'd1,
    MODE_LONG   = 2'd2,
    MODE_RSVD   = 2'd3
  } execMode_t;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trackState_t;

  localparam int DOM_SUP  = 0;
  localparam int DOM_USER = 1;
  localparam int NUM_DOM  = 2;

  localparam int          FAULT_CODE_W   = 8;
  localparam logic [7:0]  FAULT_CODE_LAND = 8'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic faultFire;
  } ctrlStrobe_t;

endpackage

// File: rtl/blg_decode.sv
module blg_decode
  import blg_pkg::*;
(
  input  logic               retValid,
  input  logic [2:0]         retClass,
  input  logic               retNoTrack,
  input  logic [1:0]         retMode,
  input  logic               retPriv,
  input  logic               retLegacy,
  input  logic               masterEn,
  input  logic               userEn,
  input  logic               supEn,
  output logic               armReq,
  output logic               markOk,
  output logic               legacyHit,
  output logic [NUM_DOM-1:0] domSel,
  output logic [NUM_DOM-1:0] domEnable
);

  instClass_t cls;
  execMode_t  mode;
  logic       isIndirect;
  logic       mark32Ok;
  logic       mark64Ok;

  assign cls  = instClass_t'(retClass);
  assign mode = execMode_t'(retMode);

  always_comb begin
    isIndirect = 1'b0;
    mark32Ok   = 1'b0;
    mark64Ok   = 1'b0;
    case (cls)
      CLS_ICALL,
      CLS_IJMP:   isIndirect = 1'b1;
      CLS_MARK32: mark32Ok   = (mode == MODE_PROT32) || (mode == MODE_COMPAT);
      CLS_MARK64: mark64Ok   = (mode == MODE_LONG);
      default:    ;
    endcase
  end

  assign armReq    = isIndirect && !retNoTrack;
  assign markOk    = mark32Ok || mark64Ok;
  assign legacyHit = retLegacy;

  always_comb begin
    domSel              = '0;
    domSel[DOM_USER]    = retValid && retPriv;
    domSel[DOM_SUP]     = retValid && !retPriv;
    domEnable           = '0;
    domEnable[DOM_USER] = masterEn && userEn;
    domEnable[DOM_SUP]  = masterEn && supEn;
  end

endmodule

// File: rtl/blg_ctrl.sv
module blg_ctrl
  import blg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               armReq,
  input  logic               markOk,
  input  logic               legacyHit,
  input  logic [NUM_DOM-1:0] domSel,
  input  logic [NUM_DOM-1:0] domEnable,
  output logic [NUM_DOM-1:0] domWait,
  output ctrlStrobe_t        strobe
);

  logic [NUM_DOM-1:0] domFault;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    trackState_t stateQ;
    trackState_t stateD;

    always_comb begin
      stateD      = stateQ;
      domFault[d] = 1'b0;
      if (!domEnable[d]) begin
        stateD = TRK_IDLE;
      end else if (domSel[d]) begin
        case (stateQ)
          TRK_IDLE: begin
            if (armReq) stateD = TRK_WAIT;
          end
          TRK_WAIT: begin
            stateD = TRK_IDLE;
            if (!legacyHit && !markOk) domFault[d] = 1'b1;
          end
          default: stateD = TRK_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) stateQ <= TRK_IDLE;
      else       stateQ <= stateD;
    end

    assign domWait[d] = (stateQ == TRK_WAIT);
  end

  assign strobe.faultFire = |domFault;

endmodule

// File: rtl/blg_datapath.sv
module blg_datapath
  import blg_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       retAddr,
  output logic                    faultPulse,
  output logic [FAULT_CODE_W-1:0] faultCode,
  output logic [ADDR_W-1:0]       faultAddr
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      faultCode  <= '0;
      faultAddr  <= '0;
    end else begin
      faultPulse <= strobe.faultFire;
      if (strobe.faultFire) begin
        faultCode <= FAULT_CODE_LAND;
        faultAddr <= retAddr;
      end
    end
  end

endmodule

// File: rtl/branch_land_guard.sv
module branch_land_guard
  import blg_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              userEn,
  input  logic              supEn,
  input  logic              retValid,
  input  logic [2:0]        retClass,
  input  logic              retNoTrack,
  input  logic [1:0]        retMode,
  input  logic              retPriv,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic              retLegacy,
  output logic              trackUser,
  output logic              trackSup,
  output logic              faultPulse,
  output logic [7:0]        faultCode,
  output logic [ADDR_W-1:0] faultAddr
);

  logic               armReq;
  logic               markOk;
  logic               legacyHit;
  logic [NUM_DOM-1:0] domSel;
  logic [NUM_DOM-1:0] domEnable;
  logic [NUM_DOM-1:0] domWait;
  ctrlStrobe_t        strobe;

  blg_decode u_decode (
    .retValid  (retValid),
    .retClass  (retClass),
    .retNoTrack(retNoTrack),
    .retMode   (retMode),
    .retPriv   (retPriv),
    .retLegacy (retLegacy),
    .masterEn  (masterEn),
    .userEn    (userEn),
    .supEn     (supEn),
    .armReq    (armReq),
    .markOk    (markOk),
    .legacyHit (legacyHit),
    .domSel    (domSel),
    .domEnable (domEnable)
  );

  blg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armReq   (armReq),
    .markOk   (markOk),
    .legacyHit(legacyHit),
    .domSel   (domSel),
    .domEnable(domEnable),
    .domWait  (domWait),
    .strobe   (strobe)
  );

  blg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .retAddr   (retAddr),
    .faultPulse(faultPulse),
    .faultCode (faultCode),
    .faultAddr (faultAddr)
  );

  assign trackUser = domWait[DOM_USER];
  assign trackSup  = domWait[DOM_SUP];

endmodule

// File: rtl/blg_checker.sv
module blg_checker #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              masterEn,
  input logic              userEn,
  input logic              supEn,
  input logic              retValid,
  input logic              retNoTrack,
  input logic              retPriv,
  input logic              trackUser,
  input logic              trackSup,
  input logic              faultPulse,
  input logic [7:0]        faultCode,
  input logic [ADDR_W-1:0] faultAddr
);

  AST_ARM_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackUser) |-> $past(retValid && retPriv)); // R2

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (faultCode == 8'd3)); // R4

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> $past(retValid)); // R4

  AST_NO_TRACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && retPriv && !trackUser && retNoTrack) |=> !trackUser); // R5

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |=> (!trackUser && !trackSup)); // R8

  AST_DOMAIN_SEP: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && !retPriv && masterEn && userEn) |=> $stable(trackUser)); // R10

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !faultPulse |-> ($stable(faultAddr) && $stable(faultCode))); // R11

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!retValid && masterEn && userEn && supEn) |=>
      ($stable(trackUser) && $stable(trackSup))); // R12

endmodule

bind branch_land_guard blg_checker #(.ADDR_W(ADDR_W)) u_blg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .masterEn  (masterEn),
  .userEn    (userEn),
  .supEn     (supEn),
  .retValid  (retValid),
  .retNoTrack(retNoTrack),
  .retPriv   (retPriv),
  .trackUser (trackUser),
  .trackSup  (trackSup),
  .faultPulse(faultPulse),
  .faultCode (faultCode),
  .faultAddr (faultAddr)
);

// File: tb/test_branch_land_guard.sv
`timescale 1ns/1ps
module test_branch_land_guard;

  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          masterEn = 1'b1, userEn = 1'b1, supEn = 1'b1;
  logic          retValid = 1'b0;
  logic [2:0]    retClass = '0;
  logic          retNoTrack = 1'b0;
  logic [1:0]    retMode = 2'd2;
  logic          retPriv = 1'b1;
  logic [AW-1:0] retAddr = '0;
  logic          retLegacy = 1'b0;
  logic          trackUser, trackSup, faultPulse;
  logic [7:0]    faultCode;
  logic [AW-1:0] faultAddr;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;
  logic [AW-1:0] expQ[$];

  always #2 clk = ~clk;

  branch_land_guard #(.ADDR_W(AW)) i_branch_land_guard (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .userEn(userEn), .supEn(supEn),
    .retValid(retValid), .retClass(retClass), .retNoTrack(retNoTrack),
    .retMode(retMode), .retPriv(retPriv), .retAddr(retAddr), .retLegacy(retLegacy),
    .trackUser(trackUser), .trackSup(trackSup), .faultPulse(faultPulse),
    .faultCode(faultCode), .faultAddr(faultAddr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one descriptor; return after the edge that consumes it.
  task automatic send(input logic [2:0] cls, input logic nt, input logic [1:0] mode,
                      input logic priv, input logic [AW-1:0] addr, input logic leg);
    retValid = 1'b1; retClass = cls; retNoTrack = nt; retMode = mode;
    retPriv = priv; retAddr = addr; retLegacy = leg;
    @(negedge clk);
    retValid = 1'b0; retNoTrack = 1'b0; retLegacy = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // Monitor: every fault pulse must match the head of the expectation queue (R4)
  always @(negedge clk) begin
    if (rstN && faultPulse) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected fault", faultAddr, 0);
      end else begin
        logic [AW-1:0] e;
        e = expQ.pop_front();
        check(faultAddr == e, "R4 fault address", faultAddr, e);
        check(faultCode == 8'd3, "R4 fault code", faultCode, 8'd3);
      end
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(trackUser == 0 && trackSup == 0, "R1 track", {trackUser, trackSup}, 0);
    check(faultPulse == 0 && faultCode == 0 && faultAddr == 0, "R1 fault regs",
          faultAddr, 0);
    rstN = 1'b1;
    idle();

    // R2 arm on indirect call, R3 release on matching 64-bit marker
    send(3'd1, 0, 2'd2, 1, 48'h1000, 0);
    check(trackUser == 1, "R2 arm call", trackUser, 1);
    send(3'd4, 0, 2'd2, 1, 48'h2000, 0);
    check(trackUser == 0 && faultPulse == 0, "R3 release", {trackUser, faultPulse}, 0);

    // R4 violation on plain instruction after indirect jump
    send(3'd2, 0, 2'd2, 1, 48'h3000, 0);
    check(trackUser == 1, "R2 arm jump", trackUser, 1);
    expQ.push_back(48'h100);
    send(3'd0, 0, 2'd2, 1, 48'h100, 0);
    check(faultPulse == 1 && trackUser == 0, "R4 pulse and idle",
          {faultPulse, trackUser}, 2'b10);
    idle();
    check(faultPulse == 0, "R4 single cycle pulse", faultPulse, 0);
    check(faultAddr == 48'h100 && faultCode == 8'd3, "R11 hold", faultAddr, 48'h100);

    // R4 an offending indirect call does not re-arm
    send(3'd1, 0, 2'd2, 1, 48'h3100, 0);
    expQ.push_back(48'h110);
    send(3'd1, 0, 2'd2, 1, 48'h110, 0);
    check(trackUser == 0, "R4 no re-arm", trackUser, 0);

    // R5 no-track prefix
    send(3'd1, 1, 2'd2, 1, 48'h4000, 0);
    check(trackUser == 0, "R5 no-track call", trackUser, 0);
    send(3'd2, 1, 2'd2, 1, 48'h4010, 0);
    check(trackUser == 0, "R5 no-track jump", trackUser, 0);
    send(3'd0, 0, 2'd2, 1, 48'h4020, 0);
    check(faultPulse == 0, "R5 no fault after exempt", faultPulse, 0);

    // R6 mode-correct markers
    send(3'd1, 0, 2'd0, 1, 48'h5000, 0);
    send(3'd3, 0, 2'd0, 1, 48'h5010, 0);
    check(trackUser == 0 && faultPulse == 0, "R6 32-bit marker prot32",
          {trackUser, faultPulse}, 0);
    send(3'd1, 0, 2'd1, 1, 48'h5020, 0);
    send(3'd3, 0, 2'd1, 1, 48'h5030, 0);
    check(trackUser == 0 && faultPulse == 0, "R6 32-bit marker compat",
          {trackUser, faultPulse}, 0);
    send(3'd1, 0, 2'd2, 1, 48'h5040, 0);
    expQ.push_back(48'h200);
    send(3'd3, 0, 2'd2, 1, 48'h200, 0);
    check(faultPulse == 1, "R6 32-bit marker in 64-bit mode", faultPulse, 1);
    send(3'd1, 0, 2'd0, 1, 48'h5050, 0);
    expQ.push_back(48'h210);
    send(3'd4, 0, 2'd0, 1, 48'h210, 0);
    check(faultPulse == 1, "R6 64-bit marker in 32-bit mode", faultPulse, 1);

    // R7 legacy page escape
    send(3'd2, 0, 2'd2, 1, 48'h6000, 0);
    send(3'd0, 0, 2'd2, 1, 48'h6010, 1);
    check(trackUser == 0 && faultPulse == 0, "R7 legacy", {trackUser, faultPulse}, 0);

    // R9 marker while idle
    send(3'd4, 0, 2'd2, 1, 48'h7000, 0);
    check(trackUser == 0 && faultPulse == 0, "R9 idle marker",
          {trackUser, faultPulse}, 0);
    check(faultAddr == 48'h210, "R11 hold after idle marker", faultAddr, 48'h210);

    // R10 domain separation
    send(3'd1, 0, 2'd2, 1, 48'h8000, 0);
    send(3'd1, 0, 2'd2, 0, 48'h8010, 0);
    check(trackUser == 1 && trackSup == 1, "R10 both armed", {trackUser, trackSup}, 2'b11);
    send(3'd4, 0, 2'd2, 0, 48'h8020, 0);
    check(trackUser == 1 && trackSup == 0, "R10 sup release keeps user",
          {trackUser, trackSup}, 2'b10);
    send(3'd4, 0, 2'd2, 1, 48'h8030, 0);
    check(trackUser == 0 && faultPulse == 0, "R10 user release", trackUser, 0);

    // R12 quiet cycles hold the wait
    send(3'd2, 0, 2'd2, 1, 48'h9000, 0);
    idle(); idle(); idle();
    check(trackUser == 1, "R12 hold while no descriptor", trackUser, 1);
    send(3'd4, 0, 2'd2, 1, 48'h9010, 0);

    // R8 enables
    masterEn = 1'b0; idle();
    send(3'd1, 0, 2'd2, 1, 48'hA000, 0);
    send(3'd1, 0, 2'd2, 0, 48'hA010, 0);
    check(trackUser == 0 && trackSup == 0, "R8 master off", {trackUser, trackSup}, 0);
    masterEn = 1'b1; idle();
    send(3'd1, 0, 2'd2, 1, 48'hA020, 0);
    check(trackUser == 1, "R8 re-enabled arm", trackUser, 1);
    userEn = 1'b0; idle();
    check(trackUser == 0, "R8 user disable clears", trackUser, 0);
    send(3'd1, 0, 2'd2, 0, 48'hA030, 0);
    check(trackSup == 1, "R8 supervisor still tracks", trackSup, 1);
    userEn = 1'b1; supEn = 1'b0; idle();
    check(trackSup == 0, "R8 sup disable clears", trackSup, 0);
    supEn = 1'b1; idle();

    repeat (2) idle();
    check(expQ.size() == 0, "R4 all expected faults seen", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule